// File: doc/BRIEF.md
# Pipelined Mantissa Base-2 Logarithm (Taylor Expansion About 1.5)

This block computes the fractional part of a base-2 logarithm for a normalised mantissa m in [1, 2). It is meant to sit next to a leading-one detector. That detector supplies the integer part, and the fraction from this block is added to it. The block evaluates a four-term power series of ln(m) expanded about m = 1.5. It then scales the result to base 2 and adds the constant log2(1.5). Because the expansion point is the centre of the interval, the residual error stays small and roughly balanced at both ends, so no bias correction is applied.

Let d = m − 1.5. The block builds d², d³ and d⁴ with a chain of multipliers, one power per pipeline stage. The lower powers are delayed so that all four are present in the same stage. Four more multipliers scale each power by its fixed coefficient. The resulting terms are summed in a two-level adder tree together with the constant. The sum is clamped into the unsigned output range. A new mantissa can be accepted on every clock, and each result appears a fixed number of cycles later.

Top module: `tlog2_taylor`

## Requirements
- R1: `in_mant` is an unsigned fixed-point value with one integer bit and 15 fraction bits (value = code / 32768), and every accepted input has its MSB set, so that m lies in [1, 2). `out_frac` is an unsigned fraction with 16 fraction bits (value = code / 65536).
- R2: For every input in the domain, |out_frac/65536 − log2(m)| ≤ 0.0025.
- R3: The input m = 1.5 (code 0xC000) yields exactly 38336, which is the stored constant log2(1.5) in 16 fraction bits.
- R4: The input m = 1.0 (code 0x8000) yields exactly 108. At this input the truncated series leaves a small positive value, and the result does not wrap below zero.
- R5: The output is clamped to the codes 0 through 0xFFFF. The largest input (0xFFFF) yields a code of at least 0xFE00 and never wraps to a small value.
- R6: `out_valid` rises exactly 8 rising clock edges after the edge that accepts `in_valid`, counting the accepting edge as the first.
- R7: The block accepts one input on every clock. Inputs sent back to back produce results back to back, in the same order, with none lost or added.
- R8: While `rst_n` is low, and until the first result, `out_valid` is 0 and `out_frac` is 0. The block accepts inputs from the third rising edge after `rst_n` is released.
- R9: On every cycle in which `out_valid` is low, `out_frac` keeps the last result it presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Marks `in_mant` as a new operand this cycle |
| in_mant | input | MW (16) | Mantissa in [1,2), with 1 integer bit and MW−1 fraction bits |
| out_valid | output | 1 | Marks `out_frac` as a new result this cycle |
| out_frac | output | OW (16) | log2 of the mantissa as an unsigned fraction |

## Verification
The bench sweeps the whole mantissa range and also sends pseudo-random operands with bubbles in between. Each result is compared against a real-valued logarithm, so a wrong coefficient, a wrong sign or a power chain that has lost alignment shows up as an error well beyond the tolerance. The two ends of the interval are checked on their own. At m = 1.0 a design that dropped the clamp or mis-signed d would wrap to a code near 0xFFFF, and at the top input a wrap would give a code near zero. The exact centre value exposes any error in the constant term or in how it is aligned. Latency is measured for every result, and outputs are watched across idle cycles. This catches a design that loses or duplicates results in a burst, or one that lets the output register change without a valid result.

// File: rtl/tlog2_pkg.sv
package tlog2_pkg;

  // Coefficients are signed values with 2 integer bits and CF fraction bits.
  localparam int CF    = 16;
  localparam int CW    = CF + 2;
  localparam int NTERM = 4;
  // Pipeline depth: operand stage, NTERM-1 power stages, term stage,
  // two adder stages and the clamp stage.
  localparam int LAT   = NTERM + 4;

  // log2(1.5) scaled by 2^CF.
  localparam int C0 = 38336;

  // Term n weight: (-1)^(n+1) / (n * 1.5^n * ln 2), scaled by 2^CF and rounded.
  function automatic int coef(input int n);
    case (n)
      1:       return 63032;
      2:       return -21011;
      3:       return 9338;
      4:       return -4669;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/tlog2_mul_stage.sv
// One power step: y <= (a * b) >>> FRAC, loaded when en is high.
module tlog2_mul_stage #(
  parameter int W    = 17,
  parameter int FRAC = 15
) (
  input  logic                clk,
  input  logic                en,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] prod;
  logic signed [W-1:0]  y_nxt;

  always_comb begin
    prod  = a * b;
    y_nxt = W'(prod >>> FRAC);
  end

  always_ff @(posedge clk) begin
    if (en) y <= y_nxt;
  end
endmodule

// File: rtl/tlog2_delay.sv
// Alignment delay line; register i loads when en[i] is high.
module tlog2_delay #(
  parameter int W     = 17,
  parameter int DEPTH = 1
) (
  input  logic                clk,
  input  logic [DEPTH-1:0]    en,
  input  logic signed [W-1:0] d,
  output logic signed [W-1:0] q
);
  logic [W-1:0] sr [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (en[0]) sr[0] <= d;
    for (int i = 1; i < DEPTH; i++) begin
      if (en[i]) sr[i] <= sr[i-1];
    end
  end

  assign q = sr[DEPTH-1];
endmodule

// File: rtl/tlog2_term.sv
// Scales one power by its fixed series weight.
module tlog2_term #(
  parameter int PW   = 17,
  parameter int CW   = 18,
  parameter int COEF = 0
) (
  input  logic                   clk,
  input  logic                   en,
  input  logic signed [PW-1:0]   p,
  output logic signed [PW+CW-1:0] t
);
  localparam logic signed [CW-1:0] K = CW'(COEF);

  logic signed [PW+CW-1:0] t_nxt;

  always_comb begin
    t_nxt = K * p;
  end

  always_ff @(posedge clk) begin
    if (en) t <= t_nxt;
  end
endmodule

// File: rtl/tlog2_taylor.sv
module tlog2_taylor
  import tlog2_pkg::*;
#(
  parameter int MW = 16,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [MW-1:0] in_mant,
  output logic          out_valid,
  output logic [OW-1:0] out_frac
);
  localparam int MF = MW - 1;        // fraction bits of d and the powers
  localparam int DW = MW + 1;        // signed width of d and the powers
  localparam int TW = DW + CW;       // width of a scaled term
  localparam int SF = MF + CF;       // fraction bits of terms and sum
  localparam int SW = TW + 2;        // width of the final sum
  localparam logic signed [DW-1:0] MID = DW'(3) <<< (MF - 1);
  localparam longint C0L = longint'(C0) * (longint'(1) << MF);
  localparam logic signed [SW-1:0] C0S = SW'(C0L);
  localparam logic signed [SW-1:0] ONE = SW'(longint'(1) << SF);

  // Reset: asserted at once, released on the clock.
  logic [1:0] rsync;
  logic       rs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rs_n = rsync[1];

  // Valid pipeline; v[k] qualifies the data loaded at stage k+1.
  logic [LAT:1] vr;
  logic [LAT:0] v;

  assign v = {vr, in_valid};

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) vr <= '0;
    else       vr <= v[LAT-1:0];
  end

  // Stage 1: offset from the expansion point.
  logic signed [DW-1:0] d_nxt, d_r;

  always_comb begin
    d_nxt = $signed({1'b0, in_mant}) - MID;
  end

  always_ff @(posedge clk) begin
    if (v[0]) d_r <= d_nxt;
  end

  // Power chain: pw[k] = d^k, ready after stage k.
  logic signed [DW-1:0] pw [1:NTERM];
  logic signed [DW-1:0] dd [2:NTERM-1];
  logic signed [DW-1:0] al [1:NTERM];

  assign pw[1] = d_r;

  for (genvar j = 2; j < NTERM; j++) begin : g_dpipe
    if (j == 2) begin : g_first
      always_ff @(posedge clk) begin
        if (v[j-1]) dd[j] <= d_r;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (v[j-1]) dd[j] <= dd[j-1];
      end
    end
  end

  for (genvar k = 2; k <= NTERM; k++) begin : g_pow
    logic signed [DW-1:0] bsel;
    if (k == 2) begin : g_b0
      assign bsel = d_r;
    end else begin : g_bn
      assign bsel = dd[k-1];
    end
    tlog2_mul_stage #(.W(DW), .FRAC(MF)) u_mul (
      .clk (clk),
      .en  (v[k-1]),
      .a   (pw[k-1]),
      .b   (bsel),
      .y   (pw[k])
    );
  end

  // Align every power to stage NTERM.
  for (genvar k = 1; k <= NTERM; k++) begin : g_align
    if (k < NTERM) begin : g_dly
      tlog2_delay #(.W(DW), .DEPTH(NTERM - k)) u_dly (
        .clk (clk),
        .en  (v[NTERM-1:k]),
        .d   (pw[k]),
        .q   (al[k])
      );
    end else begin : g_pass
      assign al[k] = pw[k];
    end
  end

  // Term stage.
  logic signed [TW-1:0] tm [1:NTERM];

  for (genvar n = 1; n <= NTERM; n++) begin : g_term
    tlog2_term #(.PW(DW), .CW(CW), .COEF(coef(n))) u_term (
      .clk (clk),
      .en  (v[NTERM]),
      .p   (al[n]),
      .t   (tm[n])
    );
  end

  // Adder tree: pairs, then total plus constant.
  logic signed [TW:0]   sa_nxt, sb_nxt, sa, sb;
  logic signed [SW-1:0] tot_nxt, tot;

  always_comb begin
    sa_nxt = (TW+1)'(tm[1]) + (TW+1)'(tm[2]);
    sb_nxt = (TW+1)'(tm[3]) + (TW+1)'(tm[4]);
  end

  always_ff @(posedge clk) begin
    if (v[NTERM+1]) begin
      sa <= sa_nxt;
      sb <= sb_nxt;
    end
  end

  always_comb begin
    tot_nxt = SW'(sa) + SW'(sb) + C0S;
  end

  always_ff @(posedge clk) begin
    if (v[NTERM+2]) tot <= tot_nxt;
  end

  // Clamp into [0, 1 - 2^-OW].
  logic [OW-1:0] out_nxt;

  always_comb begin
    if (tot < 0)          out_nxt = '0;
    else if (tot >= ONE)  out_nxt = '1;
    else                  out_nxt = OW'(tot >>> (SF - OW));
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n)              out_frac <= '0;
    else if (v[LAT-1])      out_frac <= out_nxt;
  end

  assign out_valid = v[LAT];
endmodule

// File: rtl/tlog2_taylor_chk.sv
module tlog2_taylor_chk
  import tlog2_pkg::*;
#(
  parameter int MW = 16,
  parameter int OW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [MW-1:0] in_mant,
  input logic          out_valid,
  input logic [OW-1:0] out_frac
);
  localparam int WARM = LAT + 2;
  localparam logic [MW-1:0] CENTRE = MW'(3) << (MW - 2);
  localparam logic [MW-1:0] UNITY  = MW'(1) << (MW - 1);
  localparam int CEXP = (OW <= CF) ? (C0 >>> (CF - OW)) : (C0 <<< (OW - CF));

  logic [LAT-1:0] sh_v, sh_c, sh_u;
  int             cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_v <= '0;
      sh_c <= '0;
      sh_u <= '0;
      cnt  <= 0;
    end else begin
      sh_v <= {sh_v[LAT-2:0], in_valid};
      sh_c <= {sh_c[LAT-2:0], in_valid && (in_mant == CENTRE)};
      sh_u <= {sh_u[LAT-2:0], in_valid && (in_mant == UNITY)};
      if (cnt < WARM) cnt <= cnt + 1;
    end
  end

  a_r1_domain: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_mant[MW-1]);

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == WARM) |-> (out_valid == sh_v[LAT-1]));

  a_r3_centre: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == WARM && sh_c[LAT-1]) |-> (out_valid && out_frac == OW'(CEXP)));

  if (MW == 16 && OW == 16) begin : g_unity
    a_r4_unity: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == WARM && sh_u[LAT-1]) |-> (out_valid && out_frac == 16'd108));
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_frac));
endmodule

bind tlog2_taylor tlog2_taylor_chk #(.MW(MW), .OW(OW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_mant   (in_mant),
  .out_valid (out_valid),
  .out_frac  (out_frac)
);

// File: tb/sim_tlog2_taylor.sv
`timescale 1ns/1ps
module sim_tlog2_taylor;
  localparam int MW  = 16;
  localparam int OW  = 16;
  localparam int LAT = 8;
  localparam real TOL = 0.0025;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [MW-1:0] in_mant = '0;
  logic          out_valid;
  logic [OW-1:0] out_frac;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int sent = 0;
  int got = 0;
  int q_m[$];
  int q_t[$];
  int q_x[$];
  int last_out = 0;
  bit last_seen = 1'b0;
  bit done = 1'b0;

  tlog2_taylor #(.MW(MW), .OW(OW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mant   (in_mant),
    .out_valid (out_valid),
    .out_frac  (out_frac)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // xflag: >=0 exact code, -1 tolerance only, -2 top-end bound
  task automatic send(input int m, input int xflag);
    @(negedge clk);
    in_valid = 1'b1;
    in_mant  = MW'(m);
    q_m.push_back(m);
    q_t.push_back(cyc);
    q_x.push_back(xflag);
    sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic summary;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      got++;
      if (q_m.size() == 0) begin
        check(1'b0, "R7", "unexpected result", int'(out_frac), -1);
      end else begin
        int m, t0, xf, code;
        real mr, ex, gr, err;
        m  = q_m.pop_front();
        t0 = q_t.pop_front();
        xf = q_x.pop_front();
        code = int'(out_frac);
        check(cyc - t0 == LAT, "R6", "latency", cyc - t0, LAT);
        mr = real'(m) / 32768.0;
        ex = $ln(mr) / $ln(2.0);
        if (ex < 0.0) ex = 0.0;
        if (ex > 65535.0 / 65536.0) ex = 65535.0 / 65536.0;
        gr  = real'(code) / 65536.0;
        err = (gr > ex) ? gr - ex : ex - gr;
        if (xf == 38336)
          check(code == xf, "R3", "centre value", code, xf);
        else if (xf == 108)
          check(code == xf, "R4", "unity value", code, xf);
        else if (xf == -2)
          check(code >= 16'hFE00, "R5", "top end clamp", code, 16'hFE00);
        check(err <= TOL, "R2", $sformatf("error at m=0x%04h", m),
              code, int'(ex * 65536.0));
      end
      last_out  = int'(out_frac);
      last_seen = 1'b1;
    end else if (rst_n && last_seen) begin
      check(int'(out_frac) == last_out, "R9", "hold between results",
            int'(out_frac), last_out);
    end
  end

  initial begin
    int lfsr;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R8", "valid in reset", int'(out_valid), 0);
    check(out_frac == '0, "R8", "data in reset", int'(out_frac), 0);
    rst_n = 1'b1;
    idle(4);
    check(out_valid == 1'b0, "R8", "valid after reset", int'(out_valid), 0);
    check(out_frac == '0, "R8", "data after reset", int'(out_frac), 0);

    // Endpoints and centre (R3, R4, R5, R1 domain)
    send(16'hC000, 38336);
    send(16'h8000, 108);
    send(16'hFFFF, -2);
    idle(14);

    // Back-to-back sweep of the whole domain (R2, R7)
    for (int m = 16'h8000; m <= 16'hFFFF; m += 8) send(m, -1);
    idle(3);

    // Pseudo-random operands with bubbles (R2, R6, R9)
    lfsr = 16'hACE1;
    for (int i = 0; i < 1500; i++) begin
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
      if (lfsr[0]) idle(1 + (lfsr[3:1] & 3));
      send(lfsr | 16'h8000, -1);
    end
    idle(LAT + 6);

    check(q_m.size() == 0, "R7", "results pending", q_m.size(), 0);
    check(got == sent, "R7", "result count", got, sent);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", got, sent);
      summary();
      $finish;
    end
  end
endmodule